// File: doc/BRIEF.md
# Accumulator Processor Core with Pointer Addressing

This block is a small multi-cycle processor. It has a single 16-bit accumulator and a 12-bit program counter, and it steps through a fetch, decode and execute loop. Its working store is a synchronous RAM of 4096 words of 16 bits, held inside the block. Every access to that RAM goes through a registered address (MAR) and the registered read word (MDR). Each instruction word carries a 4-bit operation code in bits 15:12 and a 12-bit address in bits 11:0. Instructions that take no address leave the low field at zero. Numbers are in sign/magnitude form: bit 15 is the sign and bits 14:0 are the magnitude.

Words enter and leave the core on two valid/ready streams. An input instruction raises `in_ready` and waits for as long as `in_valid` stays low, so the producer sets the pace. An output instruction raises `out_valid` and holds `out_data` steady until `out_ready` is seen, so the consumer can apply back-pressure for any number of cycles. A word moves only in a cycle where both valid and ready are high. To load a program, the surrounding logic holds reset and writes words through a plain preload port. Releasing reset then starts execution at address 0. The run flag, the error bit, the PC and the accumulator are available as plain status pins.

Top module: `acc_core`

## Requirements
- R1: While `rst_n` is low and after it rises, the PC reads 0, the accumulator reads 0, `running` is 1 and `arith_err` is 0. The first instruction is fetched from address 0 in the cycle after reset is released.
- R2: When `ld_en` is high at a clock edge, `ld_data` is written to the RAM word at `ld_addr`. The preload port is used while reset is held.
- R3: Opcode 0001 loads the accumulator from the word at the address field and takes 4 cycles. Opcode 0010 writes the accumulator to that word and takes 3 cycles. Both then step the PC by 1.
- R4: Opcode 0011 adds the addressed word to the accumulator in sign/magnitude and takes 4 cycles. With unlike signs, the smaller magnitude is subtracted from the larger and the result takes the sign of the larger. A zero result is always written as +0 (0x0000).
- R5: If an add with like signs carries out of the 15-bit magnitude, `arith_err` becomes 1 and stays 1 until reset. The accumulator takes the low 15 bits of the magnitude, with the sign rule of R4.
- R6: Opcode 0111 loads the PC from the address field and takes 2 cycles.
- R7: Opcode 1000 takes 2 cycles. It adds 2 to the PC when the accumulator holds 0x0000 or 0x8000, and adds 1 otherwise.
- R8: Opcode 1011 reads the word at the address field and uses its low 12 bits as the operand address, then loads that operand into the accumulator; it takes 6 cycles. Opcode 1100 finds the address the same way and writes the accumulator there; it takes 5 cycles.
- R9: Opcode 0101 raises `in_ready` from its third cycle onward until a cycle where `in_valid` is high. In that cycle the accumulator takes `in_data` and the PC steps by 1. `in_ready` and `out_valid` are never high together.
- R10: Opcode 0110 raises `out_valid` from its third cycle, with `out_data` equal to the accumulator. Both stay unchanged until a cycle where `out_ready` is high, and the PC then steps by 1.
- R11: Opcode 0000 clears `running` at the end of its second cycle. After that, PC, accumulator and the stream handshakes no longer change, and the PC keeps the address of the halt word.
- R12: Opcodes 0100, 1001, 1010, 1101, 1110 and 1111 change nothing except the PC, which steps by 1, and take 2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Preload write enable |
| ld_addr | input | 12 | Preload word address |
| ld_data | input | 16 | Preload word |
| in_valid | input | 1 | Input stream word is valid |
| in_ready | output | 1 | Core is waiting for an input word |
| in_data | input | 16 | Input stream word |
| out_valid | output | 1 | Output stream word is valid |
| out_ready | input | 1 | Consumer accepts the output word |
| out_data | output | 16 | Output stream word (the accumulator) |
| running | output | 1 | Run flag |
| arith_err | output | 1 | Sticky arithmetic overflow flag |
| pc_o | output | 12 | Program counter |
| acc_o | output | 16 | Accumulator |

## Verification
A wrong state transition changes how many cycles an instruction takes. The PC then steps in the wrong cycle, or `in_ready`/`out_valid` rises early or late, and a per-cycle comparison of the PC and the handshake pins catches this at the first misplaced edge. A bad MAR or a wrong pointer word is harder to see: a wrong RAM location shows only when a later load, pointer load or output brings it back to the accumulator. For that reason the test programs read back every stored word within a few instructions. A wrong sign/magnitude result or a wrong error flag appears on `acc_o` or `arith_err` one cycle after the last cycle of the add.

// File: rtl/core_pkg.sv
package core_pkg;
  localparam logic [3:0] OP_HALT   = 4'b0000;
  localparam logic [3:0] OP_LOAD   = 4'b0001;
  localparam logic [3:0] OP_STORE  = 4'b0010;
  localparam logic [3:0] OP_ADD    = 4'b0011;
  localparam logic [3:0] OP_IN     = 4'b0101;
  localparam logic [3:0] OP_OUT    = 4'b0110;
  localparam logic [3:0] OP_JUMP   = 4'b0111;
  localparam logic [3:0] OP_SKIPZ  = 4'b1000;
  localparam logic [3:0] OP_LOADI  = 4'b1011;
  localparam logic [3:0] OP_STOREI = 4'b1100;

  typedef enum logic [3:0] {
    ST_FETCH, ST_DECODE, ST_PTR, ST_AIM, ST_READ,
    ST_EXEC, ST_WRITE, ST_IN, ST_OUT, ST_HALT
  } state_e;
endpackage

// File: rtl/core_ram.sv
module core_ram #(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/sm_adder.sv
module sm_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         ovf
);
  localparam int MW = W - 1;
  logic [MW:0]   ma, mb, same;
  logic [MW-1:0] mag;
  logic          sgn;

  always_comb begin
    ma   = {1'b0, a[MW-1:0]};
    mb   = {1'b0, b[MW-1:0]};
    same = ma + mb;
    ovf  = 1'b0;
    if (a[MW] == b[MW]) begin
      mag = same[MW-1:0];
      ovf = same[MW];
      sgn = a[MW];
    end else if (ma >= mb) begin
      mag = ma[MW-1:0] - mb[MW-1:0];
      sgn = a[MW];
    end else begin
      mag = mb[MW-1:0] - ma[MW-1:0];
      sgn = b[MW];
    end
    sum = {sgn & (|mag), mag};
  end
endmodule

// File: rtl/core_ctrl.sv
module core_ctrl
  import core_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] mdr,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] alu_sum,
  input  logic          alu_ovf,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          running,
  output logic          arith_err,
  output logic [AW-1:0] pc,
  output logic [DW-1:0] acc
);
  localparam int OPW = DW - AW;

  state_e         state;
  logic [OPW-1:0] ir_op;
  logic [AW-1:0]  mar;
  logic [OPW-1:0] dec_op;
  logic           acc_zero;

  assign dec_op   = mdr[DW-1 -: OPW];
  assign acc_zero = ~|acc[DW-2:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_FETCH;
      pc        <= '0;
      acc       <= '0;
      running   <= 1'b1;
      arith_err <= 1'b0;
      ir_op     <= '0;
      mar       <= '0;
    end else begin
      case (state)
        ST_FETCH: state <= ST_DECODE;
        ST_DECODE: begin
          ir_op <= dec_op;
          mar   <= mdr[AW-1:0];
          case (dec_op)
            OP_HALT: begin
              running <= 1'b0;
              state   <= ST_HALT;
            end
            OP_LOAD, OP_ADD:     state <= ST_READ;
            OP_STORE:            state <= ST_WRITE;
            OP_LOADI, OP_STOREI: state <= ST_PTR;
            OP_IN:               state <= ST_IN;
            OP_OUT:              state <= ST_OUT;
            OP_JUMP: begin
              pc    <= mdr[AW-1:0];
              state <= ST_FETCH;
            end
            OP_SKIPZ: begin
              pc    <= pc + (acc_zero ? AW'(2) : AW'(1));
              state <= ST_FETCH;
            end
            default: begin
              pc    <= pc + AW'(1);
              state <= ST_FETCH;
            end
          endcase
        end
        ST_PTR: state <= ST_AIM;
        ST_AIM: begin
          mar   <= mdr[AW-1:0];
          state <= (ir_op == OP_LOADI) ? ST_READ : ST_WRITE;
        end
        ST_READ: state <= ST_EXEC;
        ST_EXEC: begin
          if (ir_op == OP_ADD) begin
            acc <= alu_sum;
            if (alu_ovf) arith_err <= 1'b1;
          end else begin
            acc <= mdr;
          end
          pc    <= pc + AW'(1);
          state <= ST_FETCH;
        end
        ST_WRITE: begin
          pc    <= pc + AW'(1);
          state <= ST_FETCH;
        end
        ST_IN: begin
          if (in_valid) begin
            acc   <= in_data;
            pc    <= pc + AW'(1);
            state <= ST_FETCH;
          end
        end
        ST_OUT: begin
          if (out_ready) begin
            pc    <= pc + AW'(1);
            state <= ST_FETCH;
          end
        end
        default: state <= ST_HALT;
      endcase
    end
  end

  assign mem_addr  = (state == ST_FETCH) ? pc : mar;
  assign mem_we    = (state == ST_WRITE);
  assign mem_wdata = acc;
  assign in_ready  = (state == ST_IN);
  assign out_valid = (state == ST_OUT);
  assign out_data  = acc;
endmodule

// File: rtl/acc_core.sv
module acc_core #(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          running,
  output logic          arith_err,
  output logic [AW-1:0] pc_o,
  output logic [DW-1:0] acc_o
);
  logic [AW-1:0] core_addr, ram_addr;
  logic          core_we, ram_we;
  logic [DW-1:0] core_wdata, ram_wdata, mdr;
  logic [DW-1:0] alu_sum;
  logic          alu_ovf;

  assign ram_addr  = ld_en ? ld_addr : core_addr;
  assign ram_we    = ld_en | core_we;
  assign ram_wdata = ld_en ? ld_data : core_wdata;

  core_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(ram_wdata), .rdata(mdr)
  );

  sm_adder #(.W(DW)) u_alu (
    .a(acc_o), .b(mdr), .sum(alu_sum), .ovf(alu_ovf)
  );

  core_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .mdr(mdr),
    .mem_addr(core_addr), .mem_we(core_we), .mem_wdata(core_wdata),
    .alu_sum(alu_sum), .alu_ovf(alu_ovf),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .running(running), .arith_err(arith_err), .pc(pc_o), .acc(acc_o)
  );
endmodule

// File: rtl/acc_core_sva.sv
module acc_core_sva #(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [DW-1:0] in_data,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          running,
  input logic          arith_err,
  input logic [AW-1:0] pc_o,
  input logic [DW-1:0] acc_o
);
  p_halt_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> !running && $stable(pc_o) && $stable(acc_o));

  p_halt_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !in_ready && !out_valid);

  p_out_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  p_in_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready && !in_valid |=> in_ready && $stable(acc_o) && $stable(pc_o));

  p_in_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready && in_valid |=> acc_o == $past(in_data) && !in_ready);

  p_one_dir_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    arith_err |=> arith_err);
endmodule

bind acc_core acc_core_sva #(.AW(AW), .DW(DW)) u_sva (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .running(running), .arith_err(arith_err),
  .pc_o(pc_o), .acc_o(acc_o)
);

// File: tb/acc_core_bench.sv
`timescale 1ns/100ps
module acc_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_en = 1'b0;
  logic [11:0] ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        out_ready = 1'b0;
  logic        in_ready, out_valid, running, arith_err;
  logic [15:0] out_data, acc_o;
  logic [11:0] pc_o;

  always #2.5 clk = ~clk;

  acc_core u_acc_core (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .running(running), .arith_err(arith_err), .pc_o(pc_o), .acc_o(acc_o)
  );

  int checks = 0;
  int errors = 0;

  logic [15:0] m_mem [4096];
  logic [11:0] m_pc;
  logic [15:0] m_acc;
  logic        m_run, m_aeb;
  logic [15:0] inq[$];
  logic [15:0] got_out[$];
  logic [15:0] exp_out[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'b0000: return "R11";
      4'b0001, 4'b0010: return "R3";
      4'b0011: return "R4";
      4'b0101: return "R9";
      4'b0110: return "R10";
      4'b0111: return "R6";
      4'b1000: return "R7";
      4'b1011, 4'b1100: return "R8";
      default: return "R12";
    endcase
  endfunction

  function automatic int lat_of(input logic [3:0] op);
    case (op)
      4'b0001, 4'b0011: return 4;
      4'b0010: return 3;
      4'b1011: return 6;
      4'b1100: return 5;
      default: return 2;
    endcase
  endfunction

  // Sign/magnitude reference add: returns {overflow, result}
  function automatic logic [16:0] sm_ref(input logic [15:0] a, input logic [15:0] b);
    int va, vb, s, mag;
    logic o;
    va = a[15] ? -int'(a[14:0]) : int'(a[14:0]);
    vb = b[15] ? -int'(b[14:0]) : int'(b[14:0]);
    s = va + vb;
    mag = (s < 0) ? -s : s;
    o = (mag > 32767);
    if (o) mag = mag - 32768;
    return {o, (s < 0) && (mag != 0), mag[14:0]};
  endfunction

  task automatic put(input int a, input logic [15:0] w);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = 12'(a); ld_data = w;
    m_mem[a] = w;
    @(posedge clk);
    #1 ld_en = 1'b0;
  endtask

  initial begin
    int cyc, post, phase;
    logic [3:0] op;
    logic [11:0] a;
    logic [16:0] r;
    bit done, exp_in_rdy, exp_out_vld;
    string t;

    for (int i = 0; i < 4096; i++) m_mem[i] = '0;
    // R2: program preloaded through the preload port while reset is held
    put(0,  16'h1014); put(1,  16'h3015); put(2,  16'h6000); put(3,  16'hB016);
    put(4,  16'h6000); put(5,  16'h5000); put(6,  16'hC017); put(7,  16'h101A);
    put(8,  16'h6000); put(9,  16'h8000); put(10, 16'h700C); put(11, 16'h0000);
    put(12, 16'h5000); put(13, 16'h8000); put(14, 16'h0000); put(15, 16'h9000);
    put(16, 16'h101B); put(17, 16'h301C); put(18, 16'h6000); put(19, 16'h0000);
    put(20, 16'h0005); put(21, 16'h8003); put(22, 16'h0019); put(23, 16'h001A);
    put(25, 16'h1234); put(26, 16'hFFFF); put(27, 16'h7FFF); put(28, 16'h0001);
    inq = '{16'h8007, 16'h8000};
    exp_out = '{16'h0002, 16'h1234, 16'h8007, 16'h0000};
    m_pc = '0; m_acc = '0; m_run = 1'b1; m_aeb = 1'b0;

    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(pc_o == 12'd0 && acc_o == 16'h0 && running && !arith_err, "R1",
          "reset state pc/acc", {pc_o[11:0], acc_o[3:0]}, 16'h0);

    cyc = 0; post = 0; phase = 0;
    while ((m_run || post < 12) && cyc < 3000) begin
      in_valid  = (inq.size() > 0) && (cyc % 4 != 1);
      in_data   = (inq.size() > 0) ? inq[0] : 16'h0;
      out_ready = (cyc % 3 != 0);
      #1;
      op = m_mem[m_pc][15:12];
      a  = m_mem[m_pc][11:0];
      t  = tag_of(op);
      exp_in_rdy  = m_run && op == 4'b0101 && phase >= 2;
      exp_out_vld = m_run && op == 4'b0110 && phase >= 2;
      check(running == m_run, t, "running", {15'h0, running}, {15'h0, m_run});
      check(pc_o == m_pc, t, "pc", {4'h0, pc_o}, {4'h0, m_pc});
      check(acc_o == m_acc, t, "acc", acc_o, m_acc);
      check(arith_err == m_aeb, "R5", "arith_err", {15'h0, arith_err}, {15'h0, m_aeb});
      check(in_ready == exp_in_rdy, "R9", "in_ready", {15'h0, in_ready}, {15'h0, exp_in_rdy});
      check(out_valid == exp_out_vld, "R10", "out_valid", {15'h0, out_valid}, {15'h0, exp_out_vld});
      if (exp_out_vld) check(out_data == m_acc, "R10", "out_data", out_data, m_acc);
      if (out_valid && out_ready) got_out.push_back(out_data);

      if (m_run) begin
        if (op == 4'b0101)      done = (phase >= 2) && in_valid;
        else if (op == 4'b0110) done = (phase >= 2) && out_ready;
        else                    done = (phase == lat_of(op) - 1);
        if (done) begin
          case (op)
            4'b0000: m_run = 1'b0;
            4'b0001: m_acc = m_mem[a];
            4'b0010: m_mem[a] = m_acc;
            4'b0011: begin r = sm_ref(m_acc, m_mem[a]); m_acc = r[15:0]; if (r[16]) m_aeb = 1'b1; end
            4'b0101: begin m_acc = inq[0]; void'(inq.pop_front()); end
            4'b1011: m_acc = m_mem[m_mem[a][11:0]];
            4'b1100: m_mem[m_mem[a][11:0]] = m_acc;
            default: ;
          endcase
          if (op == 4'b0111) m_pc = a;
          else if (op == 4'b1000) m_pc = m_pc + ((m_acc[14:0] == 15'h0) ? 12'd2 : 12'd1);
          else if (op != 4'b0000) m_pc = m_pc + 12'd1;
          phase = 0;
        end else begin
          phase++;
        end
      end
      cyc++;
      if (!m_run) post++;
      @(negedge clk);
    end

    if (cyc >= 3000) begin
      errors++;
      checks++;
      $display("FAIL R11 watchdog: actual %0d cycles expected halt", cyc);
    end

    // R3 R4 R8 R9 R10: output stream against hand-computed values
    check(got_out.size() == exp_out.size(), "R10", "output count",
          16'(got_out.size()), 16'(exp_out.size()));
    for (int i = 0; i < exp_out.size() && i < got_out.size(); i++)
      check(got_out[i] == exp_out[i], (i == 0) ? "R4" : (i == 1) ? "R8" : (i == 2) ? "R9" : "R5",
            "output word", got_out[i], exp_out[i]);
    // R7: -0 input skipped the halt at 14; R12: no-op at 15 passed; R11: stopped at 19
    check(pc_o == 12'd19 && !running, "R11", "final pc", {4'h0, pc_o}, 16'd19);
    check(arith_err, "R5", "overflow flag", {15'h0, arith_err}, 16'h1);
    check(acc_o == 16'h0000, "R5", "wrapped sum", acc_o, 16'h0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule